// File: doc/BRIEF.md
# Integer ALU with Carry and Overflow Flags

A purely combinational 64-bit integer stage for a fixed-point execution unit. One operand pair and a small operation code go in. A 64-bit result and the flags of the exception register come out in the same cycle. A single addition gives two sets of flags. The 64-bit carry and overflow come from bit 63. The 32-bit carry and overflow come from bit 31. The stage also handles sign extension, an addition for compares, and a byte-match test.

The flag vectors keep bit 0 for the 64-bit flag and bit 1 for the 32-bit flag. The carry input uses the same layout, but only its bit 0 feeds the addition. The summary-overflow bit comes in and goes out.

Top module: `xer_int_alu`

## Requirements
- R1: With `op_kind` = 1 (add), `{carry_out[0], result}` equals `op_a + op_b + carry_in[0]` as a 65-bit sum. `carry_in[1]` has no effect.
- R2: With add, `carry_out[1]` is bit 32 of the sum of the low 32 bits of `op_a`, the low 32 bits of `op_b` and `carry_in[0]`.
- R3: With add, `ovf_out[0]` is `(carry_out[0] ^ result[63]) & ~(op_a[63] ^ op_b[63])`.
- R4: With add, `ovf_out[1]` is `(carry_out[1] ^ result[31]) & ~(op_a[31] ^ op_b[31])`.
- R5: With `op_kind` = 2 (sign extend) and `data_len` of 1, 2 or 4, the low 8*len bits of `result` equal those of `op_a`. Every higher bit copies `op_a` bit 8*len-1. Any other `data_len` passes `op_a` through unchanged.
- R6: With `op_kind` = 3 (compare add), `result` is the low 64 bits of `op_a + op_b`. The carry input has no effect.
- R7: With `op_kind` = 4 (byte match), `result[0]` is 1 when any of the eight bytes of `op_b` equals `op_a[7:0]`. All other result bits are 0.
- R8: For the sign-extend, compare-add and byte-match operations, `carry_out` and `ovf_out` are 0 and `so_out` equals `so_in`.
- R9: For any other `op_kind` (0, 5, 6, 7), `result`, `carry_out`, `ovf_out` and `so_out` are all 0.
- R10: With add, `so_out` is `so_in | ovf_out[0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| carry_in | input | 2 | Carry in; bit 0 is the 64-bit carry, bit 1 the 32-bit carry |
| so_in | input | 1 | Summary-overflow in |
| op_kind | input | 3 | Operation code: 1 add, 2 sign extend, 3 compare add, 4 byte match |
| data_len | input | 4 | Operand size in bytes for sign extension |
| result | output | 64 | Result |
| carry_out | output | 2 | Carry out; bit 0 from bit 63, bit 1 from bit 31 |
| ovf_out | output | 2 | Signed overflow; bit 0 for 64-bit, bit 1 for 32-bit |
| so_out | output | 1 | Summary-overflow out |

## Verification
The assertions are checked whenever the combinational outputs settle. They assume the inputs are stable for the whole evaluation. They also assume the operation code only selects the defined operations or the zero default.

The bench changes inputs only on a rising clock edge. It compares outputs half a period later, so each check sees settled values. Operands are directed edge values plus random values. Some random operands have the upper 32 bits cleared, so the 32-bit and 64-bit flags differ in most cases.

// File: rtl/xer_int_alu.sv
`timescale 1ns/1ps
module xer_int_alu #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] op_a,
  input  logic [XLEN-1:0] op_b,
  input  logic [1:0]      carry_in,
  input  logic            so_in,
  input  logic [2:0]      op_kind,
  input  logic [3:0]      data_len,
  output logic [XLEN-1:0] result,
  output logic [1:0]      carry_out,
  output logic [1:0]      ovf_out,
  output logic            so_out
);
  localparam int HALF  = XLEN / 2;
  localparam int BYTES = XLEN / 8;

  localparam logic [2:0] K_ADD  = 3'd1;
  localparam logic [2:0] K_SEXT = 3'd2;
  localparam logic [2:0] K_CMP  = 3'd3;
  localparam logic [2:0] K_BEQ  = 3'd4;

  logic [HALF:0]     lo_sum, hi_sum;
  logic [XLEN-1:0]   add_res, cmp_res, sext_res;
  logic [BYTES-1:0]  byte_hit;
  logic              ov64, ov32;

  assign lo_sum  = {1'b0, op_a[HALF-1:0]} + {1'b0, op_b[HALF-1:0]} + {{HALF{1'b0}}, carry_in[0]};
  assign hi_sum  = {1'b0, op_a[XLEN-1:HALF]} + {1'b0, op_b[XLEN-1:HALF]} + {{HALF{1'b0}}, lo_sum[HALF]};
  assign add_res = {hi_sum[HALF-1:0], lo_sum[HALF-1:0]};
  assign cmp_res = op_a + op_b;

  assign ov64 = (op_a[XLEN-1] == op_b[XLEN-1]) && (add_res[XLEN-1] != op_a[XLEN-1]);
  assign ov32 = (op_a[HALF-1] == op_b[HALF-1]) && (add_res[HALF-1] != op_a[HALF-1]);

  for (genvar g = 0; g < BYTES; g++) begin : g_byte
    assign byte_hit[g] = (op_b[8*g +: 8] == op_a[7:0]);
  end

  always_comb begin
    case (data_len)
      4'd1:    sext_res = {{(XLEN-8){op_a[7]}}, op_a[7:0]};
      4'd2:    sext_res = {{(XLEN-16){op_a[15]}}, op_a[15:0]};
      4'd4:    sext_res = {{(XLEN-32){op_a[31]}}, op_a[31:0]};
      default: sext_res = op_a;
    endcase
  end

  always_comb begin
    result    = '0;
    carry_out = '0;
    ovf_out   = '0;
    so_out    = so_in;
    case (op_kind)
      K_ADD: begin
        result    = add_res;
        carry_out = {lo_sum[HALF], hi_sum[HALF]};
        ovf_out   = {ov32, ov64};
        so_out    = so_in | ov64;
      end
      K_SEXT: result = sext_res;
      K_CMP:  result = cmp_res;
      K_BEQ:  result = {{(XLEN-1){1'b0}}, |byte_hit};
      default: so_out = 1'b0;
    endcase
  end

  always_comb begin
    if (op_kind == K_ADD) begin
      p_add_sum_r1: assert ({carry_out[0], result} ==
                            {1'b0, op_a} + {1'b0, op_b} + {{XLEN{1'b0}}, carry_in[0]});
      p_no_overflow_r3: assert (ovf_out[0] ==
                            ((carry_out[0] ^ result[XLEN-1]) & ~(op_a[XLEN-1] ^ op_b[XLEN-1])));
      p_ov32_r4: assert (ovf_out[1] ==
                            ((carry_out[1] ^ result[HALF-1]) & ~(op_a[HALF-1] ^ op_b[HALF-1])));
      p_sticky_r10: assert (so_out == (so_in | ovf_out[0]));
    end
    if (op_kind == K_SEXT && data_len == 4'd1)
      p_sext_byte_r5: assert (result[XLEN-1:8] == {(XLEN-8){op_a[7]}} && result[7:0] == op_a[7:0]);
    if (op_kind == K_BEQ)
      p_beq_upper_r7: assert (result[XLEN-1:1] == '0);
    if (op_kind == K_SEXT || op_kind == K_CMP || op_kind == K_BEQ)
      p_noflag_r8: assert (carry_out == 2'b00 && ovf_out == 2'b00 && so_out == so_in);
    if (op_kind == 3'd0 || op_kind > K_BEQ)
      p_bad_op_r9: assert (result == '0 && carry_out == 2'b00 && ovf_out == 2'b00 && !so_out);
  end
endmodule

// File: tb/xer_int_alu_test.sv
`timescale 1ns/1ps
module xer_int_alu_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [63:0] a, b, res;
  logic [1:0]  ci, co, ov;
  logic        si, so;
  logic [2:0]  op;
  logic [3:0]  len;
  int checks = 0, fails = 0;
  bit done = 0;

  xer_int_alu uut (.op_a(a), .op_b(b), .carry_in(ci), .so_in(si), .op_kind(op),
                   .data_len(len), .result(res), .carry_out(co), .ovf_out(ov), .so_out(so));

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic apply(logic [2:0] k, logic [63:0] x, logic [63:0] y, logic [1:0] c, logic s, logic [3:0] l);
    @(posedge clk);
    op = k; a = x; b = y; ci = c; si = s; len = l;
    @(negedge clk);
  endtask

  task automatic add_case(logic [63:0] x, logic [63:0] y, logic [1:0] c, logic s);
    logic [64:0] full;
    logic [32:0] low;
    logic c64, c32, o64, o32;
    apply(3'd1, x, y, c, s, 4'd0);
    full = {1'b0, x} + {1'b0, y} + {64'd0, c[0]};
    low  = {1'b0, x[31:0]} + {1'b0, y[31:0]} + {32'd0, c[0]};
    c64 = full[64]; c32 = low[32];
    o64 = (c64 ^ full[63]) & ~(x[63] ^ y[63]);
    o32 = (c32 ^ full[31]) & ~(x[31] ^ y[31]);
    chk("R1 sum", res, full[63:0]);
    chk("R1 carry", {63'd0, co[0]}, {63'd0, c64});
    chk("R2 carry32", {63'd0, co[1]}, {63'd0, c32});
    chk("R3 ov", {63'd0, ov[0]}, {63'd0, o64});
    chk("R4 ov32", {63'd0, ov[1]}, {63'd0, o32});
    chk("R10 so", {63'd0, so}, {63'd0, s | o64});
  endtask

  task automatic t_add;
    add_case(64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 2'b01, 1'b0);
    add_case(64'h0000_0000_7FFF_FFFF, 64'd1, 2'b00, 1'b0);
    add_case(64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 2'b00, 1'b0);
    add_case(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 2'b00, 1'b1);
    add_case(64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, 2'b10, 1'b0);
    for (int i = 0; i < 40; i++) begin
      logic [63:0] x, y;
      x = {$urandom, $urandom}; y = {$urandom, $urandom};
      if (i % 2 == 0) begin x[63:32] = '0; y[63:32] = '0; end
      add_case(x, y, 2'($urandom), 1'($urandom));
    end
  endtask

  task automatic t_sext;
    logic [63:0] x = 64'h1234_5678_9ABC_DEF0;
    apply(3'd2, x, 64'd0, 2'b11, 1'b1, 4'd1);
    chk("R5 len1", res, 64'hFFFF_FFFF_FFFF_FFF0);
    chk("R8 flags sext", {59'd0, co, ov, so}, {59'd0, 4'd0, 1'b1});
    apply(3'd2, x, 64'd0, 2'b00, 1'b0, 4'd2);
    chk("R5 len2", res, 64'hFFFF_FFFF_FFFF_DEF0);
    apply(3'd2, x, 64'd0, 2'b00, 1'b0, 4'd4);
    chk("R5 len4", res, 64'hFFFF_FFFF_9ABC_DEF0);
    apply(3'd2, 64'h0000_0000_1234_7F70, 64'd0, 2'b00, 1'b0, 4'd2);
    chk("R5 len2 pos", res, 64'h0000_0000_0000_7F70);
    apply(3'd2, x, 64'd0, 2'b00, 1'b0, 4'd8);
    chk("R5 len8", res, x);
  endtask

  task automatic t_cmp;
    apply(3'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'd5, 2'b11, 1'b0, 4'd0);
    chk("R6 cmp", res, 64'd4);
    chk("R8 flags cmp", {59'd0, co, ov, so}, 64'd0);
    apply(3'd3, 64'd100, 64'd23, 2'b01, 1'b1, 4'd0);
    chk("R6 cmp ci", res, 64'd123);
    chk("R8 so cmp", {63'd0, so}, 64'd1);
  endtask

  task automatic t_beq;
    apply(3'd4, 64'h55, 64'h0102_0304_5506_0708, 2'b11, 1'b0, 4'd0);
    chk("R7 hit", res, 64'd1);
    chk("R8 flags beq", {59'd0, co, ov, so}, 64'd0);
    apply(3'd4, 64'hAA55, 64'h0102_0304_AA06_0708, 2'b00, 1'b0, 4'd0);
    chk("R7 miss", res, 64'd0);
    apply(3'd4, 64'h11, 64'h1100_0000_0000_0000, 2'b00, 1'b1, 4'd0);
    chk("R7 top byte", res, 64'd1);
  endtask

  task automatic t_bad;
    for (int k = 0; k < 8; k++) begin
      if (k >= 1 && k <= 4) continue;
      apply(3'(k), 64'hDEAD_BEEF_0000_0001, 64'h1, 2'b11, 1'b1, 4'd1);
      chk("R9 bad op", res, 64'd0);
      chk("R9 bad flags", {59'd0, co, ov, so}, 64'd0);
    end
  endtask

  initial begin
    op = 3'd0; a = '0; b = '0; ci = '0; si = 1'b0; len = '0;
    @(negedge clk);
    chk("R9 idle", {res[58:0], co, ov, so}, 64'd0);
    t_add;
    t_sext;
    t_cmp;
    t_beq;
    t_bad;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(5 * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule